// File: doc/BRIEF.md
# Packet Timestamp Capture Latch

This block records the system time at the moment a precise-time event packet crosses the MAC timestamp point. There are two independent directions, transmit and receive. Each direction has a capture latch that holds a time value, split into a low word and a high word, together with a valid flag. A packet parser upstream supplies one strobe per direction. On the receive side it also supplies the packet's classification fields: transport is UDP, UDP destination port, ethertype, protocol version and message type. The block decides whether that packet deserves a stamp.

A capture locks its direction. Later events are dropped silently until software reads the high word, which releases the latch. Reading only the low word leaves the lock in place. The receive side applies a filter chosen by a mode field:
- a version-1 mode that accepts one configured message type over UDP on the configured event port;
- a version-2 event mode that accepts every version-2 event message (Sync, Delay_Req, Pdelay_Req, Pdelay_Resp), carried either over UDP or as a layer-2 frame with ethertype 0x88F7 when the ethertype filter entry is armed.

The event inputs are valid-only strobes with no ready. A packet on the wire cannot be stalled, so back-pressure is never applied. An event that finds its latch locked, disabled or filtered out is discarded without trace. Control and status pins are plain levels.

Top module: `ts_capture_latch`

## Requirements
- R1: After reset both valid flags are 0 and all four timestamp words are 0.
- R2: A direction captures only while its enable (`cfg_tx_en` / `cfg_rx_en`) is 1. A qualifying strobe in cycle N sets valid after edge N, and {ts_hi, ts_lo} then equals `sys_time` as it was in cycle N.
- R3: While a direction's valid is 1, further strobes on it change neither its words nor its valid flag.
- R4: A read strobe with `*_rd_word`=1 (high word) while valid is 1 clears valid after that edge. A read strobe with `*_rd_word`=0 (low word) leaves valid at 1. In both cases the held words are unchanged.
- R5: Once released, the next qualifying strobe captures a fresh time. A strobe in the same cycle as a high-word read of a locked latch is dropped.
- R6: Transmit and receive latches are independent: a capture, hold or release on one never affects the other.
- R7: With `cfg_rx_mode`=1 (version-1 UDP mode), a receive strobe qualifies only if `rx_is_udp`=1, `rx_udp_dport` equals `cfg_evt_port`, `rx_ver`=1 and `rx_msg_type` equals `cfg_v1_msg` (0 = Sync, 1 = Delay_Req).
- R8: With `cfg_rx_mode`=2 (version-2 event mode), a receive strobe qualifies only if `rx_ver`=2 and `rx_msg_type` is 0 to 3, and either it is UDP to `cfg_evt_port` or `rx_etype`=0x88F7 with both `cfg_etf_en` and `cfg_etf_stamp` at 1.
- R9: With `cfg_rx_mode` 0 (off) or 3 (reserved), no receive strobe is captured.
- R10: A transmit strobe needs no classification: any `tx_evt` while enabled and unlocked captures.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sys_time | input | TIME_W | Current system time |
| tx_evt | input | 1 | Transmit event packet at the stamp point |
| rx_evt | input | 1 | Receive event packet at the stamp point |
| rx_is_udp | input | 1 | Receive packet is carried over UDP |
| rx_udp_dport | input | 16 | Receive UDP destination port |
| rx_etype | input | 16 | Receive ethertype |
| rx_ver | input | 4 | Receive protocol version |
| rx_msg_type | input | 4 | Receive message type |
| cfg_tx_en | input | 1 | Transmit capture enable |
| cfg_rx_en | input | 1 | Receive capture enable |
| cfg_rx_mode | input | 2 | Receive filter mode: 0 off, 1 version-1 UDP, 2 version-2 event, 3 reserved |
| cfg_evt_port | input | 16 | Event UDP port (match register bits 31:16, normally 319) |
| cfg_v1_msg | input | 4 | Accepted version-1 message type (match register low bits) |
| cfg_etf_en | input | 1 | Ethertype filter entry enable |
| cfg_etf_stamp | input | 1 | Ethertype filter entry timestamp flag |
| tx_rd_stb | input | 1 | Software read of a transmit word |
| tx_rd_word | input | 1 | Word being read: 1 high, 0 low |
| rx_rd_stb | input | 1 | Software read of a receive word |
| rx_rd_word | input | 1 | Word being read: 1 high, 0 low |
| tx_ts_lo | output | TIME_W/2 | Held transmit time, low word |
| tx_ts_hi | output | TIME_W/2 | Held transmit time, high word |
| tx_valid | output | 1 | Transmit timestamp held |
| rx_ts_lo | output | TIME_W/2 | Held receive time, low word |
| rx_ts_hi | output | TIME_W/2 | Held receive time, high word |
| rx_valid | output | 1 | Receive timestamp held |

## Verification
The bench aims at the lock. It fires strobes into a held latch, where a design without the lock would overwrite the stamp with a later time. It reads the low word alone, which a design that releases on any read would wrongly unlock. It also puts a high-word read and a strobe in the same cycle, where a design that let the release win would capture a time that software never gets to pair with its packet. On the receive side it steps each classification field just off the match (port, version, message type, ethertype, each filter flag, Follow_Up in event mode). A filter with a loose compare there would stamp general messages and lock the latch against the real event.

// File: rtl/ts_cap_pkg.sv
package ts_cap_pkg;

  typedef enum logic [1:0] {
    RXM_OFF    = 2'd0,
    RXM_V1_L4  = 2'd1,
    RXM_V2_EVT = 2'd2,
    RXM_RSVD   = 2'd3
  } rx_mode_e;

  localparam int unsigned DIR_TX = 0;
  localparam int unsigned DIR_RX = 1;
  localparam int unsigned N_DIR  = 2;

  // version-2 event message types occupy codes below this limit
  localparam int unsigned V2_EVT_TYPES = 4;

endpackage

// File: rtl/ts_rx_filter.sv
module ts_rx_filter
  import ts_cap_pkg::*;
#(
  parameter int unsigned PORT_W   = 16,
  parameter int unsigned MT_W     = 4,
  parameter int unsigned VER_W    = 4,
  parameter logic [15:0] ETYPE_TS = 16'h88F7
) (
  input  logic [1:0]        mode,
  input  logic              is_udp,
  input  logic [PORT_W-1:0] dport,
  input  logic [15:0]       etype,
  input  logic [VER_W-1:0]  ver,
  input  logic [MT_W-1:0]   mtype,
  input  logic [PORT_W-1:0] cfg_port,
  input  logic [MT_W-1:0]   cfg_msg,
  input  logic              etf_en,
  input  logic              etf_stamp,
  output logic              hit
);

  localparam logic [VER_W-1:0] VER_ONE = VER_W'(1);
  localparam logic [VER_W-1:0] VER_TWO = VER_W'(2);
  localparam logic [MT_W-1:0]  EVT_LIM = MT_W'(V2_EVT_TYPES);

  logic udp_ok;
  logic l2_ok;
  logic v2_event;

  assign udp_ok   = is_udp && (dport == cfg_port);
  assign l2_ok    = etf_en && etf_stamp && (etype == ETYPE_TS);
  assign v2_event = (mtype < EVT_LIM);

  always_comb begin
    case (rx_mode_e'(mode))
      RXM_V1_L4:  hit = udp_ok && (ver == VER_ONE) && (mtype == cfg_msg);
      RXM_V2_EVT: hit = (udp_ok || l2_ok) && (ver == VER_TWO) && v2_event;
      default:    hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/ts_word_latch.sv
module ts_word_latch #(
  parameter int unsigned TIME_W = 64,
  localparam int unsigned WORD_W = TIME_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              release_hi,
  input  logic [TIME_W-1:0] stamp,
  output logic [WORD_W-1:0] lo,
  output logic [WORD_W-1:0] hi,
  output logic              held
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held <= 1'b0;
      lo   <= '0;
      hi   <= '0;
    end else if (!held) begin
      if (take) begin
        lo   <= stamp[WORD_W-1:0];
        hi   <= stamp[TIME_W-1:WORD_W];
        held <= 1'b1;
      end
    end else if (release_hi) begin
      held <= 1'b0;
    end
  end

endmodule

// File: rtl/ts_capture_latch.sv
module ts_capture_latch
  import ts_cap_pkg::*;
#(
  parameter int unsigned TIME_W   = 64,
  parameter logic [15:0] ETYPE_TS = 16'h88F7,
  localparam int unsigned WORD_W  = TIME_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TIME_W-1:0] sys_time,
  input  logic              tx_evt,
  input  logic              rx_evt,
  input  logic              rx_is_udp,
  input  logic [15:0]       rx_udp_dport,
  input  logic [15:0]       rx_etype,
  input  logic [3:0]        rx_ver,
  input  logic [3:0]        rx_msg_type,
  input  logic              cfg_tx_en,
  input  logic              cfg_rx_en,
  input  logic [1:0]        cfg_rx_mode,
  input  logic [15:0]       cfg_evt_port,
  input  logic [3:0]        cfg_v1_msg,
  input  logic              cfg_etf_en,
  input  logic              cfg_etf_stamp,
  input  logic              tx_rd_stb,
  input  logic              tx_rd_word,
  input  logic              rx_rd_stb,
  input  logic              rx_rd_word,
  output logic [WORD_W-1:0] tx_ts_lo,
  output logic [WORD_W-1:0] tx_ts_hi,
  output logic              tx_valid,
  output logic [WORD_W-1:0] rx_ts_lo,
  output logic [WORD_W-1:0] rx_ts_hi,
  output logic              rx_valid
);

  logic              rx_hit;
  logic [N_DIR-1:0]  take_v;
  logic [N_DIR-1:0]  rel_v;
  logic [N_DIR-1:0]  held_v;
  logic [WORD_W-1:0] lo_a [N_DIR];
  logic [WORD_W-1:0] hi_a [N_DIR];

  ts_rx_filter #(
    .PORT_W  (16),
    .MT_W    (4),
    .VER_W   (4),
    .ETYPE_TS(ETYPE_TS)
  ) rx_filt_i (
    .mode     (cfg_rx_mode),
    .is_udp   (rx_is_udp),
    .dport    (rx_udp_dport),
    .etype    (rx_etype),
    .ver      (rx_ver),
    .mtype    (rx_msg_type),
    .cfg_port (cfg_evt_port),
    .cfg_msg  (cfg_v1_msg),
    .etf_en   (cfg_etf_en),
    .etf_stamp(cfg_etf_stamp),
    .hit      (rx_hit)
  );

  assign take_v[DIR_TX] = tx_evt && cfg_tx_en;
  assign take_v[DIR_RX] = rx_evt && cfg_rx_en && rx_hit;
  assign rel_v[DIR_TX]  = tx_rd_stb && tx_rd_word;
  assign rel_v[DIR_RX]  = rx_rd_stb && rx_rd_word;

  for (genvar d = 0; d < N_DIR; d++) begin : g_dir
    ts_word_latch #(.TIME_W(TIME_W)) latch_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .take      (take_v[d]),
      .release_hi(rel_v[d]),
      .stamp     (sys_time),
      .lo        (lo_a[d]),
      .hi        (hi_a[d]),
      .held      (held_v[d])
    );
  end

  assign tx_ts_lo = lo_a[DIR_TX];
  assign tx_ts_hi = hi_a[DIR_TX];
  assign tx_valid = held_v[DIR_TX];
  assign rx_ts_lo = lo_a[DIR_RX];
  assign rx_ts_hi = hi_a[DIR_RX];
  assign rx_valid = held_v[DIR_RX];

endmodule

// File: rtl/ts_capture_latch_chk.sv
module ts_capture_latch_chk #(
  parameter int unsigned TIME_W = 64,
  localparam int unsigned WORD_W = TIME_W / 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [TIME_W-1:0] sys_time,
  input logic              tx_evt,
  input logic              rx_evt,
  input logic [3:0]        rx_ver,
  input logic [3:0]        rx_msg_type,
  input logic              cfg_tx_en,
  input logic              cfg_rx_en,
  input logic [1:0]        cfg_rx_mode,
  input logic              tx_rd_stb,
  input logic              tx_rd_word,
  input logic              rx_rd_stb,
  input logic              rx_rd_word,
  input logic [WORD_W-1:0] tx_ts_lo,
  input logic [WORD_W-1:0] tx_ts_hi,
  input logic              tx_valid,
  input logic [WORD_W-1:0] rx_ts_lo,
  input logic [WORD_W-1:0] rx_ts_hi,
  input logic              rx_valid
);

  assert_tx_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_valid && tx_evt && cfg_tx_en) |=>
      (tx_valid && {tx_ts_hi, tx_ts_lo} == $past(sys_time)));

  assert_tx_disabled_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_valid && !cfg_tx_en) |=> !tx_valid);

  assert_tx_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !(tx_rd_stb && tx_rd_word)) |=>
      (tx_valid && $stable(tx_ts_lo) && $stable(tx_ts_hi)));

  assert_rx_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !(rx_rd_stb && rx_rd_word)) |=>
      (rx_valid && $stable(rx_ts_lo) && $stable(rx_ts_hi)));

  assert_tx_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_rd_stb && tx_rd_word) |=> !tx_valid);

  assert_rx_lo_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_rd_stb && !rx_rd_word) |=> rx_valid);

  assert_rx_v1_version_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_valid && cfg_rx_mode == 2'd1 && rx_evt && rx_ver != 4'd1) |=> !rx_valid);

  assert_rx_v2_general_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_valid && cfg_rx_mode == 2'd2 && rx_evt && rx_msg_type[3:2] != 2'b00) |=> !rx_valid);

  assert_rx_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_valid && (!cfg_rx_en || cfg_rx_mode == 2'd0 || cfg_rx_mode == 2'd3)) |=> !rx_valid);

endmodule

bind ts_capture_latch ts_capture_latch_chk #(.TIME_W(TIME_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .sys_time   (sys_time),
  .tx_evt     (tx_evt),
  .rx_evt     (rx_evt),
  .rx_ver     (rx_ver),
  .rx_msg_type(rx_msg_type),
  .cfg_tx_en  (cfg_tx_en),
  .cfg_rx_en  (cfg_rx_en),
  .cfg_rx_mode(cfg_rx_mode),
  .tx_rd_stb  (tx_rd_stb),
  .tx_rd_word (tx_rd_word),
  .rx_rd_stb  (rx_rd_stb),
  .rx_rd_word (rx_rd_word),
  .tx_ts_lo   (tx_ts_lo),
  .tx_ts_hi   (tx_ts_hi),
  .tx_valid   (tx_valid),
  .rx_ts_lo   (rx_ts_lo),
  .rx_ts_hi   (rx_ts_hi),
  .rx_valid   (rx_valid)
);

// File: tb/ts_capture_latch_tb_top.sv
module ts_capture_latch_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] sys_time = 64'h0000_0001_0000_0000;
  logic        tx_evt = 0, rx_evt = 0, rx_is_udp = 0;
  logic [15:0] rx_udp_dport = 0, rx_etype = 0;
  logic [3:0]  rx_ver = 0, rx_msg_type = 0;
  logic        cfg_tx_en = 0, cfg_rx_en = 0;
  logic [1:0]  cfg_rx_mode = 0;
  logic [15:0] cfg_evt_port = 16'd319;
  logic [3:0]  cfg_v1_msg = 0;
  logic        cfg_etf_en = 0, cfg_etf_stamp = 0;
  logic        tx_rd_stb = 0, tx_rd_word = 0, rx_rd_stb = 0, rx_rd_word = 0;
  logic [31:0] tx_ts_lo, tx_ts_hi, rx_ts_lo, rx_ts_hi;
  logic        tx_valid, rx_valid;

  int    n_cmp = 0;
  int    n_bad = 0;
  string phase = "R1";

  always #10 clk = ~clk;

  ts_capture_latch dut_i (.*);

  // free-running system time, moved away from the active edge
  always @(negedge clk) sys_time <= sys_time + 64'h0000_0003_0123_4567;

  // ---------------- behavioural reference ----------------
  bit          m_valid [2];
  logic [63:0] m_ts    [2];

  function automatic bit rx_wanted();
    bit on_port = rx_is_udp && (rx_udp_dport == cfg_evt_port);
    bit on_l2   = (rx_etype == 16'h88F7) && cfg_etf_en && cfg_etf_stamp;
    if (cfg_rx_mode == 2'd1)
      return on_port && rx_ver == 4'd1 && rx_msg_type == cfg_v1_msg;
    if (cfg_rx_mode == 2'd2)
      return (on_port || on_l2) && rx_ver == 4'd2 && rx_msg_type <= 4'd3;
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_valid[0] = 0; m_valid[1] = 0; m_ts[0] = 0; m_ts[1] = 0;
    end else begin
      if (!m_valid[0]) begin
        if (tx_evt && cfg_tx_en) begin m_valid[0] = 1; m_ts[0] = sys_time; end
      end else if (tx_rd_stb && tx_rd_word) m_valid[0] = 0;
      if (!m_valid[1]) begin
        if (rx_evt && cfg_rx_en && rx_wanted()) begin m_valid[1] = 1; m_ts[1] = sys_time; end
      end else if (rx_rd_stb && rx_rd_word) m_valid[1] = 0;
    end
  end

  always @(negedge clk) begin
    n_cmp++;
    if (tx_valid !== m_valid[0] || {tx_ts_hi, tx_ts_lo} !== m_ts[0]) begin
      n_bad++;
      $display("FAIL %s tx: valid=%0b ts=%h expected valid=%0b ts=%h",
               phase, tx_valid, {tx_ts_hi, tx_ts_lo}, m_valid[0], m_ts[0]);
    end
    n_cmp++;
    if (rx_valid !== m_valid[1] || {rx_ts_hi, rx_ts_lo} !== m_ts[1]) begin
      n_bad++;
      $display("FAIL %s rx: valid=%0b ts=%h expected valid=%0b ts=%h",
               phase, rx_valid, {rx_ts_hi, rx_ts_lo}, m_valid[1], m_ts[1]);
    end
  end

  // ---------------- stimulus helpers (enter and leave at negedge) ----------------
  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tx_pulse();
    tx_evt = 1; @(negedge clk); tx_evt = 0;
  endtask

  task automatic rx_pkt(bit udp, logic [15:0] port, logic [15:0] et,
                        logic [3:0] ver, logic [3:0] mt);
    rx_is_udp = udp; rx_udp_dport = port; rx_etype = et;
    rx_ver = ver; rx_msg_type = mt; rx_evt = 1;
    @(negedge clk);
    rx_evt = 0;
  endtask

  task automatic rd_tx(bit hi);
    tx_rd_stb = 1; tx_rd_word = hi; @(negedge clk); tx_rd_stb = 0; tx_rd_word = 0;
  endtask

  task automatic rd_rx(bit hi);
    rx_rd_stb = 1; rx_rd_word = hi; @(negedge clk); rx_rd_stb = 0; rx_rd_word = 0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    summary();
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1;
    phase = "R1"; idle(3);

    phase = "R2"; tx_pulse(); idle(2);          // disabled: no capture
    cfg_tx_en = 1;
    phase = "R10"; tx_pulse(); idle(2);         // plain capture
    phase = "R3"; tx_pulse(); tx_pulse(); idle(2);
    phase = "R4"; rd_tx(0); idle(2); rd_tx(1); idle(2); rd_tx(1); idle(1);
    phase = "R5"; tx_pulse(); idle(1);
    tx_evt = 1; tx_rd_stb = 1; tx_rd_word = 1;  // release and strobe together
    @(negedge clk); tx_evt = 0; tx_rd_stb = 0; tx_rd_word = 0;
    idle(2); tx_pulse(); idle(1); rd_tx(1);

    phase = "R7"; cfg_rx_en = 1; cfg_rx_mode = 2'd1; cfg_v1_msg = 4'd0;
    rx_pkt(1, 16'd320, 0, 4'd1, 4'd0);           // wrong port
    rx_pkt(0, 16'd319, 0, 4'd1, 4'd0);           // not UDP
    rx_pkt(1, 16'd319, 0, 4'd2, 4'd0);           // wrong version
    rx_pkt(1, 16'd319, 0, 4'd1, 4'd1);           // Delay_Req not selected
    rx_pkt(1, 16'd319, 0, 4'd1, 4'd0);           // Sync accepted
    idle(1); rd_rx(1);
    cfg_v1_msg = 4'd1;
    rx_pkt(1, 16'd319, 0, 4'd1, 4'd0);
    rx_pkt(1, 16'd319, 0, 4'd1, 4'd1);
    idle(1); rd_rx(1);

    phase = "R8"; cfg_rx_mode = 2'd2;
    for (int t = 0; t < 10; t++) begin
      rx_pkt(1, 16'd319, 0, 4'd2, 4'(t));
      idle(1); rd_rx(1);
    end
    rx_pkt(1, 16'd319, 0, 4'd1, 4'd0);           // version 1 rejected
    rx_pkt(0, 0, 16'h88F7, 4'd2, 4'd2);          // filter entry disarmed
    cfg_etf_en = 1;
    rx_pkt(0, 0, 16'h88F7, 4'd2, 4'd2);          // flag missing
    cfg_etf_stamp = 1;
    rx_pkt(0, 0, 16'h88F6, 4'd2, 4'd2);          // wrong ethertype
    rx_pkt(0, 0, 16'h88F7, 4'd2, 4'd3);          // peer-delay over layer 2
    idle(1); rd_rx(1);

    phase = "R9";
    cfg_rx_mode = 2'd0; rx_pkt(1, 16'd319, 16'h88F7, 4'd2, 4'd0);
    cfg_rx_mode = 2'd3; rx_pkt(1, 16'd319, 16'h88F7, 4'd2, 4'd0);
    idle(2);

    phase = "R6"; cfg_rx_mode = 2'd2;
    tx_pulse(); rx_pkt(1, 16'd319, 0, 4'd2, 4'd1);
    rd_tx(1); tx_pulse(); rd_rx(0); idle(1); rd_rx(1);
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r = $urandom;
      tx_evt = r[0]; tx_rd_stb = r[1]; tx_rd_word = r[2];
      rx_rd_stb = r[3]; rx_rd_word = r[4]; cfg_rx_mode = r[6:5];
      cfg_v1_msg = {3'b0, r[7]}; rx_is_udp = r[8];
      rx_udp_dport = r[9] ? 16'd319 : 16'd320;
      rx_etype = r[10] ? 16'h88F7 : 16'h0800;
      rx_ver = {2'b0, r[12:11]}; rx_msg_type = r[16:13];
      cfg_etf_stamp = r[17]; cfg_tx_en = r[18] | r[19];
      rx_evt = r[20];
      @(negedge clk);
    end
    tx_evt = 0; rx_evt = 0; tx_rd_stb = 0; rx_rd_stb = 0;
    idle(2);
    summary();
    $finish;
  end

endmodule